// File: doc/BRIEF.md
# Queue Congestion Signal Generator

This block watches queue occupancy reports and turns them into congestion signals. Each report carries the current depth of one queue, that queue's capacity, and the port and priority that own the queue. One cycle later the block returns two decisions for that report. The first says whether the departing packet gets a congestion-experienced mark. The second says whether a pause or resume event must be sent for that port and priority.

Marking follows a random-early ramp. No packet is marked at low occupancy. Packets are always marked at high occupancy. Between the two levels the chance of a mark rises in a straight line, and a pseudo-random draw settles each case. Pause control keeps one flag for each port and priority pair. A pause is raised at a trigger level and released only once occupancy drops to four fifths of that level. While a pair is paused, a per-pair watchdog counts microsecond ticks. If the pause lasts too long, the watchdog releases the pair and latches an alarm for it.

All fractions are unsigned 16-bit fixed-point values, where 65536 stands for 100 %. Occupancy is never divided out. Each comparison cross-multiplies depth and capacity instead.

Top module: `congestion_signal_gen`

## Requirements
- R1: After a synchronous active-high reset, out_valid, out_mark, out_pause, out_resume, every pair_paused bit, every wd_release bit and every wd_alarm bit are 0.
- R2: An observation with obs_valid=1 at clock edge k gives out_valid=1 after edge k, with out_port and out_prio echoing the observation. out_valid is 0 after any edge where obs_valid was 0.
- R3: With the lower level KMIN = 32768 (0.5), an observation with depth*65536 < KMIN*capacity is never marked.
- R4: With the upper level KMAX = 52429 (0.8), an observation with depth*65536 >= KMAX*capacity is always marked.
- R5: Otherwise, with PMAX = 13107 (0.2), the packet is marked exactly when r*(KMAX-KMIN)*capacity < PMAX*(depth*65536 - KMIN*capacity), where r is the current 16-bit draw. This gives a mark chance of PMAX*(usage-KMIN)/(KMAX-KMIN).
- R6: The draw comes from a 16-bit Fibonacci LFSR. Its seed is 16'hACE1. It shifts left by one bit, and the new bit 0 is s[15]^s[13]^s[12]^s[10]. The register advances once on every edge with obs_valid=1. An observation uses the value held before its own advance.
- R7: An observation with depth*65536 >= PFC_ON*capacity (PFC_ON = 55706, 0.85) for a pair that is not paused gives out_pause=1. It also sets pair_paused[port*NPRIO+prio] after the same edge.
- R8: An observation with depth*65536 < PFC_OFF*capacity (PFC_OFF = PFC_ON*4/5 = 44564) for a paused pair gives out_resume=1. It also clears that pair's pair_paused bit.
- R9: Any other observation gives neither out_pause nor out_resume, and leaves the pair's flag unchanged. This covers a high report for a pair already paused, a low report for a pair not paused, and any report inside the band between the two levels.
- R10: Each pair's flag changes only through observations addressed to that pair, or through that pair's own watchdog.
- R11: A pair that stays paused for WD_LIMIT ticks is released. One tick is TICK_DIV clock cycles. On release, wd_release for that pair pulses for one cycle and pair_paused clears. The release comes no earlier than (WD_LIMIT-1)*TICK_DIV cycles and no later than WD_LIMIT*TICK_DIV+1 cycles after the pause was set.
- R12: A watchdog release sets wd_alarm for that pair. The alarm stays set until reset, even when the pair is paused again or resumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| obs_valid | input | 1 | Observation present this cycle |
| obs_depth | input | DW | Queue depth |
| obs_cap | input | DW | Queue capacity, non-zero |
| obs_port | input | PW | Port index of the queue |
| obs_prio | input | QW | Priority index of the queue |
| out_valid | output | 1 | Decision for the previous cycle's observation |
| out_mark | output | 1 | Mark the departing packet |
| out_pause | output | 1 | Emit pause for the pair |
| out_resume | output | 1 | Emit resume (pause time zero) for the pair |
| out_port | output | PW | Port of the decision |
| out_prio | output | QW | Priority of the decision |
| pair_paused | output | NPORTS*NPRIO | Pause flag for each pair, index port*NPRIO+prio |
| wd_release | output | NPORTS*NPRIO | One-cycle forced-resume pulse for each pair |
| wd_alarm | output | NPORTS*NPRIO | Sticky watchdog alarm for each pair |

## Verification
The assertions check the invariants that must hold on every cycle. A decision only appears one cycle after an observation. Pause and resume never appear together. An emitted pause leaves its pair flagged, and an emitted resume leaves it clear. A watchdog release only comes from a paused pair and leaves it clear. Alarms never drop. Some behaviour only the bench scenarios can show: the exact mark outcome at each threshold and along the random ramp, the hysteresis band that suppresses repeated events, the independence of the pairs under random traffic, and the watchdog's timing window and its effect on later events.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

    // Fixed-point scale: 1.0 == 2**FRAC_BITS
    localparam int unsigned FRAC_BITS = 16;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    typedef enum logic [1:0] {
        FC_NONE   = 2'd0,
        FC_PAUSE  = 2'd1,
        FC_RESUME = 2'd2
    } fc_evt_e;

    typedef struct packed {
        logic    valid;
        logic    mark;
        fc_evt_e evt;
    } verdict_t;

    // Maximal-length taps 16,14,13,11 (Fibonacci form)
    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Release level of the pause hysteresis: four fifths of the trigger
    function automatic int unsigned release_level(input int unsigned trig);
        return (trig * 4) / 5;
    endfunction

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cgs_tick_gen.sv
module cgs_tick_gen #(
    parameter int unsigned DIV = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            localparam int unsigned CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (cnt == CW'(DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign tick = (cnt == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/cgs_ecn_decider.sv
module cgs_ecn_decider
    import cgs_pkg::*;
#(
    parameter int unsigned DW   = 16,
    parameter int unsigned KMIN = 32768,
    parameter int unsigned KMAX = 52429,
    parameter int unsigned PMAX = 13107
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          obs_valid,
    input  logic [DW-1:0] depth,
    input  logic [DW-1:0] cap,
    output logic          mark
);
    localparam int unsigned WW = DW + FRAC_BITS + 1;
    localparam int unsigned PW = WW + FRAC_BITS;

    logic [15:0]   draw;
    logic [WW-1:0] scaled;
    logic [WW-1:0] lo_lvl;
    logic [WW-1:0] hi_lvl;
    logic [PW-1:0] lhs;
    logic [PW-1:0] rhs;
    logic          below_lo;
    logic          at_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            draw <= LFSR_SEED;
        end else if (obs_valid) begin
            draw <= lfsr_step(draw);
        end
    end

    always_comb begin
        scaled   = WW'({depth, {FRAC_BITS{1'b0}}});
        lo_lvl   = WW'(cap) * WW'(KMIN);
        hi_lvl   = WW'(cap) * WW'(KMAX);
        below_lo = scaled < lo_lvl;
        at_hi    = scaled >= hi_lvl;
        lhs      = PW'(draw) * PW'(hi_lvl - lo_lvl);
        rhs      = PW'(PMAX) * PW'(scaled - lo_lvl);
        if (below_lo) begin
            mark = 1'b0;
        end else if (at_hi) begin
            mark = 1'b1;
        end else begin
            mark = lhs < rhs;
        end
    end
endmodule

// File: rtl/cgs_pause_tracker.sv
module cgs_pause_tracker
    import cgs_pkg::*;
#(
    parameter int unsigned NPAIRS   = 32,
    parameter int unsigned WD_LIMIT = 10000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick,
    input  logic                          obs_valid,
    input  logic [width_of(NPAIRS)-1:0]   pair_idx,
    input  logic                          hit_on,
    input  logic                          below_off,
    output fc_evt_e                       evt,
    output logic [NPAIRS-1:0]             paused,
    output logic [NPAIRS-1:0]             release_pulse,
    output logic [NPAIRS-1:0]             alarm
);
    localparam int unsigned IW = width_of(NPAIRS);
    localparam int unsigned CW = $clog2(WD_LIMIT + 1);

    logic [NPAIRS-1:0] fire;
    logic [NPAIRS-1:0] sel;
    logic              cur_paused;
    logic              idx_ok;

    assign idx_ok     = 32'(pair_idx) < NPAIRS;
    assign cur_paused = idx_ok ? paused[pair_idx] : 1'b0;

    always_comb begin
        evt = FC_NONE;
        if (obs_valid && idx_ok) begin
            if (hit_on && !cur_paused) begin
                evt = FC_PAUSE;
            end else if (below_off && cur_paused) begin
                evt = FC_RESUME;
            end
        end
    end

    genvar i;
    generate
        for (i = 0; i < NPAIRS; i++) begin : g_pair
            logic [CW-1:0] held;

            assign sel[i]  = obs_valid && (pair_idx == IW'(i));
            assign fire[i] = paused[i] && tick && (held == CW'(WD_LIMIT - 1));

            always_ff @(posedge clk) begin
                if (rst || !paused[i]) begin
                    held <= '0;
                end else if (tick) begin
                    held <= held + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    paused[i]        <= 1'b0;
                    release_pulse[i] <= 1'b0;
                    alarm[i]         <= 1'b0;
                end else begin
                    release_pulse[i] <= fire[i];
                    if (fire[i]) begin
                        alarm[i] <= 1'b1;
                    end
                    if (sel[i] && hit_on && !paused[i]) begin
                        paused[i] <= 1'b1;
                    end else if ((sel[i] && below_off && paused[i]) || fire[i]) begin
                        paused[i] <= 1'b0;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/congestion_signal_gen.sv
module congestion_signal_gen
    import cgs_pkg::*;
#(
    parameter int unsigned NPORTS   = 8,
    parameter int unsigned NPRIO    = 4,
    parameter int unsigned DW       = 16,
    parameter int unsigned KMIN     = 32768,
    parameter int unsigned KMAX     = 52429,
    parameter int unsigned PMAX     = 13107,
    parameter int unsigned PFC_ON   = 55706,
    parameter int unsigned TICK_DIV = 100,
    parameter int unsigned WD_LIMIT = 10000,
    localparam int unsigned NPAIRS  = NPORTS * NPRIO,
    localparam int unsigned PW      = width_of(NPORTS),
    localparam int unsigned QW      = width_of(NPRIO)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              obs_valid,
    input  logic [DW-1:0]     obs_depth,
    input  logic [DW-1:0]     obs_cap,
    input  logic [PW-1:0]     obs_port,
    input  logic [QW-1:0]     obs_prio,
    output logic              out_valid,
    output logic              out_mark,
    output logic              out_pause,
    output logic              out_resume,
    output logic [PW-1:0]     out_port,
    output logic [QW-1:0]     out_prio,
    output logic [NPAIRS-1:0] pair_paused,
    output logic [NPAIRS-1:0] wd_release,
    output logic [NPAIRS-1:0] wd_alarm
);
    localparam int unsigned IW      = width_of(NPAIRS);
    localparam int unsigned WW      = DW + FRAC_BITS + 1;
    localparam int unsigned PFC_OFF = release_level(PFC_ON);

    logic          tick;
    logic          mark_c;
    fc_evt_e       evt_c;
    logic [IW-1:0] pair_idx;
    logic [WW-1:0] scaled;
    logic          hit_on;
    logic          below_off;
    verdict_t      verdict_q;
    logic [PW-1:0] port_q;
    logic [QW-1:0] prio_q;

    assign pair_idx  = IW'(32'(obs_port) * NPRIO + 32'(obs_prio));
    assign scaled    = WW'({obs_depth, {FRAC_BITS{1'b0}}});
    assign hit_on    = scaled >= WW'(obs_cap) * WW'(PFC_ON);
    assign below_off = scaled <  WW'(obs_cap) * WW'(PFC_OFF);

    cgs_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    cgs_ecn_decider #(
        .DW   (DW),
        .KMIN (KMIN),
        .KMAX (KMAX),
        .PMAX (PMAX)
    ) u_ecn (
        .clk       (clk),
        .rst       (rst),
        .obs_valid (obs_valid),
        .depth     (obs_depth),
        .cap       (obs_cap),
        .mark      (mark_c)
    );

    cgs_pause_tracker #(
        .NPAIRS   (NPAIRS),
        .WD_LIMIT (WD_LIMIT)
    ) u_pfc (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .obs_valid     (obs_valid),
        .pair_idx      (pair_idx),
        .hit_on        (hit_on),
        .below_off     (below_off),
        .evt           (evt_c),
        .paused        (pair_paused),
        .release_pulse (wd_release),
        .alarm         (wd_alarm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '{valid: 1'b0, mark: 1'b0, evt: FC_NONE};
            port_q    <= '0;
            prio_q    <= '0;
        end else begin
            verdict_q.valid <= obs_valid;
            verdict_q.mark  <= obs_valid && mark_c;
            verdict_q.evt   <= obs_valid ? evt_c : FC_NONE;
            if (obs_valid) begin
                port_q <= obs_port;
                prio_q <= obs_prio;
            end
        end
    end

    assign out_valid  = verdict_q.valid;
    assign out_mark   = verdict_q.mark;
    assign out_pause  = verdict_q.evt == FC_PAUSE;
    assign out_resume = verdict_q.evt == FC_RESUME;
    assign out_port   = port_q;
    assign out_prio   = prio_q;
endmodule

// File: rtl/cgs_checker.sv
module cgs_checker #(
    parameter int unsigned NPRIO  = 4,
    parameter int unsigned NPAIRS = 32,
    parameter int unsigned PW     = 3,
    parameter int unsigned QW     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              obs_valid,
    input logic              out_valid,
    input logic              out_mark,
    input logic              out_pause,
    input logic              out_resume,
    input logic [PW-1:0]     out_port,
    input logic [QW-1:0]     out_prio,
    input logic [NPAIRS-1:0] pair_paused,
    input logic [NPAIRS-1:0] wd_release,
    input logic [NPAIRS-1:0] wd_alarm
);
    int unsigned idx;
    logic        idx_paused;
    always_comb begin
        idx        = 32'(out_port) * NPRIO + 32'(out_prio);
        idx_paused = (idx < NPAIRS) ? pair_paused[idx] : 1'b0;
    end

    assert_one_event_R7: assert property (@(posedge clk) disable iff (rst)
        !(out_pause && out_resume));

    assert_decision_needs_obs_R2: assert property (@(posedge clk) disable iff (rst)
        (out_mark || out_pause || out_resume) |-> out_valid);

    assert_valid_follows_obs_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(obs_valid)));

    assert_pause_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
        out_pause |-> idx_paused);

    assert_resume_clears_flag_R8: assert property (@(posedge clk) disable iff (rst)
        out_resume |-> !idx_paused);

    assert_release_from_paused_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((wd_release & ~$past(pair_paused)) == '0));

    assert_release_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (wd_release & pair_paused) == '0);

    assert_alarm_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((wd_alarm & $past(wd_alarm)) == $past(wd_alarm)));
endmodule

bind congestion_signal_gen cgs_checker #(
    .NPRIO  (NPRIO),
    .NPAIRS (NPAIRS),
    .PW     (PW),
    .QW     (QW)
) u_cgs_checker (
    .clk         (clk),
    .rst         (rst),
    .obs_valid   (obs_valid),
    .out_valid   (out_valid),
    .out_mark    (out_mark),
    .out_pause   (out_pause),
    .out_resume  (out_resume),
    .out_port    (out_port),
    .out_prio    (out_prio),
    .pair_paused (pair_paused),
    .wd_release  (wd_release),
    .wd_alarm    (wd_alarm)
);

// File: tb/tb_congestion_signal_gen.sv
`timescale 1ns/1ps
module tb_congestion_signal_gen;
    localparam int NP = 8, NQ = 4, NPR = 32;
    localparam longint KMIN = 32768, KMAX = 52429, PMAX = 13107;
    localparam longint PON = 55706, POFF = 44564;
    localparam int WD_DIV = 4, WD_LIM = 25;

    logic clk = 0, rst = 1;
    logic v = 0, w_v = 0;
    logic [15:0] depth = 0, cap = 1;
    logic [2:0] port = 0;
    logic [1:0] prio = 0;

    logic o_valid, o_mark, o_pause, o_resume;
    logic [2:0] o_port; logic [1:0] o_prio;
    logic [NPR-1:0] o_paused, o_rel, o_alarm;
    logic w_valid, w_mark, w_pause, w_resume;
    logic [2:0] w_port; logic [1:0] w_prio;
    logic [NPR-1:0] w_paused, w_rel, w_alarm;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [15:0] lfsr_m;
    logic [NPR-1:0] paused_m;

    always #5 clk = ~clk;

    congestion_signal_gen #(.NPORTS(NP), .NPRIO(NQ), .TICK_DIV(2), .WD_LIMIT(60000)) dut (
        .clk(clk), .rst(rst), .obs_valid(v), .obs_depth(depth), .obs_cap(cap),
        .obs_port(port), .obs_prio(prio), .out_valid(o_valid), .out_mark(o_mark),
        .out_pause(o_pause), .out_resume(o_resume), .out_port(o_port), .out_prio(o_prio),
        .pair_paused(o_paused), .wd_release(o_rel), .wd_alarm(o_alarm));

    congestion_signal_gen #(.NPORTS(NP), .NPRIO(NQ), .TICK_DIV(WD_DIV), .WD_LIMIT(WD_LIM)) dut_wd (
        .clk(clk), .rst(rst), .obs_valid(w_v), .obs_depth(depth), .obs_cap(cap),
        .obs_port(port), .obs_prio(prio), .out_valid(w_valid), .out_mark(w_mark),
        .out_pause(w_pause), .out_resume(w_resume), .out_port(w_port), .out_prio(w_prio),
        .pair_paused(w_paused), .wd_release(w_rel), .wd_alarm(w_alarm));

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic bit exp_mark(input longint d, input longint c, input longint r);
        longint sd = d * 65536, lo = KMIN * c, hi = KMAX * c;
        if (sd < lo) return 0;          // R3
        if (sd >= hi) return 1;         // R4
        return r * (hi - lo) < PMAX * (sd - lo);  // R5
    endfunction

    task automatic obs(input int p, input int q, input int d, input int c);
        bit em, ep, er;
        int idx = p * NQ + q;
        longint sd = longint'(d) * 65536;
        @(negedge clk);
        v = 1; port = 3'(p); prio = 2'(q); depth = 16'(d); cap = 16'(c);
        em = exp_mark(d, c, longint'(lfsr_m));
        ep = (sd >= PON * c) && !paused_m[idx];
        er = (sd < POFF * c) && paused_m[idx];
        if (ep) paused_m[idx] = 1'b1;
        if (er) paused_m[idx] = 1'b0;
        lfsr_m = step(lfsr_m);          // R6
        @(posedge clk);
        @(negedge clk);
        v = 0;
        chk("R2 valid", o_valid, 1);
        chk("R2 port/prio", {o_port, o_prio}, {3'(p), 2'(q)});
        chk("R3/R4/R5/R6 mark", o_mark, em);
        chk("R7 pause", o_pause, ep);
        chk("R8/R9 resume", o_resume, er);
        chk("R10 flags", o_paused, paused_m);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h5EED));
        lfsr_m = 16'hACE1; paused_m = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        chk("R1 outputs", {o_valid, o_mark, o_pause, o_resume}, 0);
        chk("R1 flags", {o_paused, o_rel, o_alarm}, 0);
        chk("R1 wd flags", {w_valid, w_paused, w_alarm}, 0);

        // ECN thresholds (cap 1000: 499 below, 500 ramp start, 800 ramp, 801 certain)
        obs(0, 0, 499, 1000);
        obs(0, 0, 500, 1000);
        obs(0, 0, 800, 1000);
        obs(0, 0, 801, 1000);
        obs(0, 0, 1000, 1000);
        for (int k = 0; k < 40; k++) obs(1, 1, 650 + k * 3, 1000);

        // Hysteresis (on: 851, off: <680)
        obs(3, 2, 850, 1000);   // band, R9
        obs(3, 2, 851, 1000);   // pause R7
        obs(3, 2, 990, 1000);   // already paused R9
        obs(3, 2, 700, 1000);   // band R9
        obs(3, 2, 680, 1000);   // band edge R9
        obs(3, 2, 679, 1000);   // resume R8
        obs(3, 2, 100, 1000);   // not paused R9

        // Idle: no decision without observation (R2)
        @(negedge clk);
        chk("R2 idle", o_valid, 0);

        // Random traffic over all pairs
        for (int k = 0; k < 3000; k++) begin
            int c = 1 + int'($urandom_range(999));
            int d = int'($urandom_range(c + c / 4));
            if ($urandom_range(3) == 0) begin
                @(negedge clk);
                chk("R2 gap", o_valid, 0);
            end
            obs(int'($urandom_range(NP - 1)), int'($urandom_range(NQ - 1)), d, c);
        end

        // Watchdog on dut_wd, pair port 2 prio 1 -> index 9
        @(negedge clk);
        w_v = 1; port = 2; prio = 1; depth = 900; cap = 1000;
        @(posedge clk); @(negedge clk);
        w_v = 0;
        chk("R7 wd pause", w_pause, 1);
        chk("R7 wd flag", w_paused[9], 1);
        n = 0;
        for (int k = 1; k <= 300; k++) begin
            @(posedge clk); @(negedge clk);
            if (w_rel[9]) begin n = k; break; end
        end
        chk("R11 release window", (n >= (WD_LIM - 1) * WD_DIV) && (n <= WD_LIM * WD_DIV + 1), 1);
        chk("R11 flag cleared", w_paused[9], 0);
        chk("R12 alarm set", w_alarm, NPR'(1) << 9);
        @(posedge clk); @(negedge clk);
        chk("R11 pulse one cycle", w_rel[9], 0);
        w_v = 1; depth = 600;
        @(posedge clk); @(negedge clk);
        w_v = 0;
        chk("R11 no resume after release", w_resume, 0);
        w_v = 1; depth = 900;
        @(posedge clk); @(negedge clk);
        w_v = 0;
        chk("R11 pause again", w_pause, 1);
        chk("R12 alarm held", w_alarm[9], 1);
        w_v = 1; depth = 10;
        @(posedge clk); @(negedge clk);
        w_v = 0;
        chk("R8 wd resume", w_resume, 1);
        chk("R12 alarm after resume", w_alarm[9], 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule